// File: doc/BRIEF.md
# Parallel Memory Side-Operation Unit

This unit carries out the small side operations that a DSP core issues next to its main instruction. Each command is one of these: a pointer adjustment, a register-to-register copy, a single load or store through a pointer, a combined load and store through two pointers, or a load of two words into the halves of the split accumulator-input registers. Every pointer that addresses memory is post-modified, either by +1 or by the index register paired with that pointer.

The unit holds sixteen 16-bit registers in one bank: pointers P0..P3 at indices 0..3, index registers X0..X3 at 4..7, the split registers A (high 8, low 9) and B (high 10, low 11), and general registers G0..G3 at 12..15. It drives a data memory with one synchronous read port (data returns one cycle after the read strobe) and one write port. A command is taken when `ready` is high. A single `done` pulse marks the cycle in which all of its register and pointer changes commit. The whole bank is visible on `reg_view` for the main datapath, with register i at bits [16i+15:16i].

Top module: `pmx_unit`

## Requirements
- R1: After reset every register is zero, `ready` is 1, `done` is 0 and neither memory strobe is active.
- R2: Opcodes 0, 1 and 2 change only pointer P[`ptr_sel`], by -1, by +1, or by adding X[`ptr_sel`]. Arithmetic is 16-bit two's complement and wraps.
- R3: Opcode 3 copies register `src_sel` into register `dst_sel` and touches no memory.
- R4: Opcode 4 writes register `src_sel` to address P[`ptr_sel`], then adds X[`ptr_sel`] to that pointer when `use_n` is 1, or +1 otherwise. There is exactly one write strobe per command.
- R5: Opcode 5 loads memory at P[`ptr_sel`] into register `dst_sel` and post-modifies that pointer in the same way as R4.
- R6: Opcode 6 loads from P0 into `dst_sel` and stores `src_sel` (its value before the command) to P3. Opcode 7 stores to P0 and loads from P3. P0 advances by X0 if `use_n` is set, else by 1. P3 advances by X3 if `use_m` is set, else by 1.
- R7: Opcode 8 reads at P[`ptr_sel`] into the high half of A (`half_a`=1) or its low half (`half_a`=0), and reads at P3 into the high or low half of B, chosen by `half_b`. Post-modify: P[`ptr_sel`] by `use_n`, P3 by `use_m`.
- R8: Opcode 9 reads at P[`ptr_sel`] into the high half and at P3 into the low half of A (`split_sel`=0) or of B (`split_sel`=1), with the same post-modify as R7.
- R9: All addresses use pointer values from before the command. Register changes appear only on the clock edge that ends the cycle in which `done` is high, and `done` is a one-cycle pulse.
- R10: Counted from the accept edge, `done` is high in the next cycle for opcodes 0–4 and reserved codes, one cycle later for 5–7, and two cycles later for 8–9. No memory strobe is active while `ready` is high.
- R11: When both post-modifies hit P3 (opcodes 8–9 with `ptr_sel`=3), the two steps add. A pointer post-modify overrides a load into that same pointer.
- R12: Opcodes 10–15 complete with `done` and change neither the registers nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command offered; taken when ready is high |
| op_code | input | 4 | Operation code (0..9; others reserved) |
| ptr_sel | input | 2 | Selected pointer |
| dst_sel | input | 4 | Destination register index |
| src_sel | input | 4 | Source register index |
| use_n | input | 1 | Selected pointer/P0 steps by its index register |
| use_m | input | 1 | P3 steps by X3 in two-pointer forms |
| half_a | input | 1 | Opcode 8: 1 = high half of A |
| half_b | input | 1 | Opcode 8: 1 = high half of B |
| split_sel | input | 1 | Opcode 9: 0 = A, 1 = B |
| ready | output | 1 | Unit idle, can take a command |
| done | output | 1 | Command commits this cycle |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 16 | Read data, one cycle after strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | 16 | Write address |
| mem_wr_data | output | 16 | Write data |
| reg_view | output | 256 | All sixteen registers, register i at [16i+15:16i] |

## Verification
The assertions check on every cycle that `done` never lasts two cycles, that the register bank holds still except on a commit edge, that no memory strobe fires while idle, and that a write strobe never repeats on consecutive cycles. Only the scenarios can show that each opcode moves the right words, steps pointers by the right amount, wraps below zero, adds the two steps on P3 and lets a post-modify win over a load into the same pointer. The latencies per opcode class and the silence of reserved codes are also shown only there.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DW     = 16;
  localparam int NPTR   = 4;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);
  localparam int PSEL_W = $clog2(NPTR);

  localparam logic [RIDX_W-1:0] RI_AH = 4'd8;
  localparam logic [RIDX_W-1:0] RI_AL = 4'd9;
  localparam logic [RIDX_W-1:0] RI_BH = 4'd10;
  localparam logic [RIDX_W-1:0] RI_BL = 4'd11;

  localparam logic [3:0] OPC_PDEC  = 4'd0;
  localparam logic [3:0] OPC_PINC  = 4'd1;
  localparam logic [3:0] OPC_PIDX  = 4'd2;
  localparam logic [3:0] OPC_MOVE  = 4'd3;
  localparam logic [3:0] OPC_STORE = 4'd4;
  localparam logic [3:0] OPC_LOAD  = 4'd5;
  localparam logic [3:0] OPC_LDST  = 4'd6;
  localparam logic [3:0] OPC_STLD  = 4'd7;
  localparam logic [3:0] OPC_DUALH = 4'd8;
  localparam logic [3:0] OPC_SPLIT = 4'd9;

  typedef struct packed {
    logic [3:0]        op;
    logic [PSEL_W-1:0] ptr;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] src;
    logic              use_n;
    logic              use_m;
    logic              half_a;
    logic              half_b;
    logic              split_sel;
  } pmx_cmd_t;

  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic op_stores(input logic [3:0] op);
    return (op == OPC_STORE) || (op == OPC_LDST) || (op == OPC_STLD);
  endfunction

  function automatic logic op_loads(input logic [3:0] op);
    return (op == OPC_LOAD) || (op == OPC_LDST) || (op == OPC_STLD) ||
           (op == OPC_DUALH) || (op == OPC_SPLIT);
  endfunction

  function automatic logic op_two_reads(input logic [3:0] op);
    return (op == OPC_DUALH) || (op == OPC_SPLIT);
  endfunction

  function automatic logic op_paired(input logic [3:0] op);
    return (op == OPC_LDST) || (op == OPC_STLD);
  endfunction

  function automatic logic op_steps_sel(input logic [3:0] op);
    return (op <= OPC_PIDX) || ((op >= OPC_STORE) && (op <= OPC_SPLIT));
  endfunction

  function automatic logic op_steps_p3(input logic [3:0] op);
    return (op >= OPC_LDST) && (op <= OPC_SPLIT);
  endfunction
endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     op_valid,
  input  pmx_cmd_t cmd_in,
  output pmx_cmd_t cmd_q,
  output logic     ready,
  output logic     in_exec,
  output logic     in_cap1,
  output logic     commit
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_CAP1, ST_CAP2} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (op_valid) st_d = ST_EXEC;
      ST_EXEC: st_d = op_loads(cmd_q.op) ? ST_CAP1 : ST_IDLE;
      ST_CAP1: st_d = op_two_reads(cmd_q.op) ? ST_CAP2 : ST_IDLE;
      ST_CAP2: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= '0;
    end else begin
      st_q <= st_d;
      if ((st_q == ST_IDLE) && op_valid) cmd_q <= cmd_in;
    end
  end

  assign ready   = (st_q == ST_IDLE);
  assign in_exec = (st_q == ST_EXEC);
  assign in_cap1 = (st_q == ST_CAP1);
  assign commit  = (in_exec && !op_loads(cmd_q.op)) ||
                   (in_cap1 && !op_two_reads(cmd_q.op)) ||
                   (st_q == ST_CAP2);

  AST_CAP_FOLLOWS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    in_cap1 |-> $past(in_exec)) else $error("cap1 without exec"); // R10
endmodule

// File: rtl/pmx_addr_gen.sv
module pmx_addr_gen
  import pmx_pkg::*;
(
  input  logic [3:0]                op,
  input  logic [PSEL_W-1:0]         ptr_sel,
  input  logic                      use_n,
  input  logic                      use_m,
  input  logic [NPTR-1:0][DW-1:0]   ptr_q,
  input  logic [NPTR-1:0][DW-1:0]   idx_q,
  output logic [DW-1:0]             rd_addr_a,
  output logic [DW-1:0]             rd_addr_b,
  output logic [DW-1:0]             wr_addr,
  output logic [NPTR-1:0]           mod_mask,
  output logic [NPTR-1:0][DW-1:0]   ptr_next
);
  localparam int P3 = NPTR - 1;

  logic [PSEL_W-1:0] sel;
  logic [DW-1:0]     step_s, step_3;
  logic              has_s, has_3;

  always_comb begin
    sel   = op_paired(op) ? '0 : ptr_sel;
    has_s = op_steps_sel(op);
    has_3 = op_steps_p3(op);
    unique case (op)
      OPC_PDEC: step_s = '1;
      OPC_PINC: step_s = DW'(1);
      OPC_PIDX: step_s = idx_q[sel];
      default:  step_s = use_n ? idx_q[sel] : DW'(1);
    endcase
    step_3 = use_m ? idx_q[P3] : DW'(1);
  end

  assign rd_addr_a = (op == OPC_STLD) ? ptr_q[P3] : ptr_q[sel];
  assign rd_addr_b = ptr_q[P3];
  assign wr_addr   = (op == OPC_LDST) ? ptr_q[P3] : ptr_q[sel];

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    logic hit_s, hit_3;
    assign hit_s = has_s && (sel == PSEL_W'(gi));
    assign hit_3 = has_3 && (gi == P3);
    assign mod_mask[gi] = hit_s || hit_3;
    assign ptr_next[gi] = wrap_add(wrap_add(ptr_q[gi], hit_s ? step_s : '0),
                                   hit_3 ? step_3 : '0);
  end
endmodule

// File: rtl/pmx_regbank.sv
module pmx_regbank
  import pmx_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wa_en,
  input  logic [RIDX_W-1:0]         wa_idx,
  input  logic [DW-1:0]             wa_data,
  input  logic                      wb_en,
  input  logic [RIDX_W-1:0]         wb_idx,
  input  logic [DW-1:0]             wb_data,
  input  logic [NPTR-1:0]           mod_en,
  input  logic [NPTR-1:0][DW-1:0]   ptr_next,
  output logic [NREG-1:0][DW-1:0]   regs_q
);
  for (genvar gr = 0; gr < NREG; gr++) begin : g_reg
    logic hit_a, hit_b;
    assign hit_a = wa_en && (wa_idx == RIDX_W'(gr));
    assign hit_b = wb_en && (wb_idx == RIDX_W'(gr));
    if (gr < NPTR) begin : g_ptr
      always_ff @(posedge clk) begin
        if (!rst_n)          regs_q[gr] <= '0;
        else if (mod_en[gr]) regs_q[gr] <= ptr_next[gr];
        else if (hit_b)      regs_q[gr] <= wb_data;
        else if (hit_a)      regs_q[gr] <= wa_data;
      end
    end else begin : g_dat
      always_ff @(posedge clk) begin
        if (!rst_n)     regs_q[gr] <= '0;
        else if (hit_b) regs_q[gr] <= wb_data;
        else if (hit_a) regs_q[gr] <= wa_data;
      end
    end
  end

  AST_PTR_MOD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en[0] |=> regs_q[0] == $past(ptr_next[0])) else $error("pointer override lost"); // R11
endmodule

// File: rtl/pmx_unit.sv
module pmx_unit
  import pmx_pkg::*;
#(
  parameter int DATA_W = pmx_pkg::DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [1:0]             ptr_sel,
  input  logic [3:0]             dst_sel,
  input  logic [3:0]             src_sel,
  input  logic                   use_n,
  input  logic                   use_m,
  input  logic                   half_a,
  input  logic                   half_b,
  input  logic                   split_sel,
  output logic                   ready,
  output logic                   done,
  output logic                   mem_rd_en,
  output logic [DATA_W-1:0]      mem_rd_addr,
  input  logic [DATA_W-1:0]      mem_rd_data,
  output logic                   mem_wr_en,
  output logic [DATA_W-1:0]      mem_wr_addr,
  output logic [DATA_W-1:0]      mem_wr_data,
  output logic [NREG*DATA_W-1:0] reg_view
);
  pmx_cmd_t cmd_in, cmd_q;
  logic in_exec, in_cap1, commit;
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NPTR-1:0][DW-1:0] ptr_next;
  logic [NPTR-1:0] mod_mask;
  logic [DW-1:0] rd_a, rd_b, wr_a, hold_q;
  logic wa_en, wb_en;
  logic [RIDX_W-1:0] wa_idx, wb_idx;
  logic [DW-1:0] wa_data, wb_data;

  assign cmd_in = '{op: op_code, ptr: ptr_sel, dst: dst_sel, src: src_sel,
                    use_n: use_n, use_m: use_m, half_a: half_a,
                    half_b: half_b, split_sel: split_sel};

  pmx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cmd_in(cmd_in),
    .cmd_q(cmd_q), .ready(ready), .in_exec(in_exec), .in_cap1(in_cap1),
    .commit(commit)
  );

  pmx_addr_gen u_agen (
    .op(cmd_q.op), .ptr_sel(cmd_q.ptr), .use_n(cmd_q.use_n), .use_m(cmd_q.use_m),
    .ptr_q(regs_q[NPTR-1:0]), .idx_q(regs_q[2*NPTR-1:NPTR]),
    .rd_addr_a(rd_a), .rd_addr_b(rd_b), .wr_addr(wr_a),
    .mod_mask(mod_mask), .ptr_next(ptr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= '0;
    else if (in_cap1) hold_q <= mem_rd_data;
  end

  always_comb begin
    wa_en = 1'b0; wa_idx = cmd_q.dst; wa_data = mem_rd_data;
    wb_en = 1'b0; wb_idx = cmd_q.dst; wb_data = mem_rd_data;
    if (commit) begin
      unique case (cmd_q.op)
        OPC_MOVE: begin
          wa_en = 1'b1; wa_data = regs_q[cmd_q.src];
        end
        OPC_LOAD, OPC_LDST, OPC_STLD: wa_en = 1'b1;
        OPC_DUALH: begin
          wa_en = 1'b1; wa_idx = cmd_q.half_a ? RI_AH : RI_AL; wa_data = hold_q;
          wb_en = 1'b1; wb_idx = cmd_q.half_b ? RI_BH : RI_BL;
        end
        OPC_SPLIT: begin
          wa_en = 1'b1; wa_idx = cmd_q.split_sel ? RI_BH : RI_AH; wa_data = hold_q;
          wb_en = 1'b1; wb_idx = cmd_q.split_sel ? RI_BL : RI_AL;
        end
        default: ;
      endcase
    end
  end

  pmx_regbank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .mod_en(commit ? mod_mask : '0), .ptr_next(ptr_next), .regs_q(regs_q)
  );

  assign done        = commit;
  assign mem_rd_en   = (in_exec && op_loads(cmd_q.op)) || (in_cap1 && op_two_reads(cmd_q.op));
  assign mem_rd_addr = in_cap1 ? rd_b : rd_a;
  assign mem_wr_en   = in_exec && op_stores(cmd_q.op);
  assign mem_wr_addr = wr_a;
  assign mem_wr_data = regs_q[cmd_q.src];
  assign reg_view    = regs_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held"); // R9
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(reg_view)) else $error("early register change"); // R9
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_rd_en && !mem_wr_en) else $error("memory strobe while idle"); // R10
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en) else $error("repeated write strobe"); // R4
endmodule

// File: tb/test_pmx_unit.sv
module test_pmx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0, dst_sel = '0, src_sel = '0;
  logic [1:0] ptr_sel = '0;
  logic use_n = 0, use_m = 0, half_a = 0, half_b = 0, split_sel = 0;
  logic ready, done, mem_rd_en, mem_wr_en;
  logic [15:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic [255:0] reg_view;

  logic [15:0] mem [256];
  logic [15:0] m_mem [256];
  logic [15:0] m_reg [16];
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmx_unit i_pmx_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .ptr_sel(ptr_sel), .dst_sel(dst_sel), .src_sel(src_sel), .use_n(use_n),
    .use_m(use_m), .half_a(half_a), .half_b(half_b), .split_sel(split_sel),
    .ready(ready), .done(done), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .reg_view(reg_view)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
    if (mem_wr_en) mem[mem_wr_addr[7:0]] <= mem_wr_data;
  end

  typedef struct packed {
    logic [3:0] op; logic [1:0] ps; logic [3:0] dst; logic [3:0] src;
    logic n; logic m; logic ha; logic hb; logic sp;
    logic [1:0] lat; logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd5, 2'd0, 4'd5,  4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2, 4'd5},  // R5 load to X1
    '{4'd5, 2'd0, 4'd4,  4'd0,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 4'd5},  // R5 step by X0=0
    '{4'd5, 2'd0, 4'd6,  4'd0,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 4'd5},  // R5 step by X0
    '{4'd5, 2'd1, 4'd7,  4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2, 4'd5},  // R5 load to X3
    '{4'd1, 2'd2, 4'd0,  4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd2},  // R2 inc
    '{4'd0, 2'd2, 4'd0,  4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd2},  // R2 dec
    '{4'd0, 2'd2, 4'd0,  4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd2},  // R2 wrap below 0
    '{4'd2, 2'd1, 4'd0,  4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd2},  // R2 add index
    '{4'd3, 2'd0, 4'd12, 4'd5,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd3},  // R3 move
    '{4'd3, 2'd0, 4'd2,  4'd12, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd3},  // R3 move to pointer
    '{4'd4, 2'd1, 4'd0,  4'd12, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd4},  // R4 store +1
    '{4'd4, 2'd2, 4'd0,  4'd5,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd4},  // R4 store +index
    '{4'd6, 2'd0, 4'd13, 4'd6,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 4'd6},  // R6 load/store n
    '{4'd7, 2'd0, 4'd14, 4'd13, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd2, 4'd6},  // R6 store/load m
    '{4'd8, 2'd1, 4'd0,  4'd0,  1'b0,1'b0,1'b1,1'b0,1'b0, 2'd3, 4'd7},  // R7 A hi, B lo
    '{4'd8, 2'd2, 4'd0,  4'd0,  1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3, 4'd7},  // R7 A lo, B hi
    '{4'd9, 2'd2, 4'd0,  4'd0,  1'b1,1'b0,1'b0,1'b0,1'b1, 2'd3, 4'd8},  // R8 fill B
    '{4'd9, 2'd3, 4'd0,  4'd0,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3, 4'd11}, // R11 both steps on P3
    '{4'd5, 2'd1, 4'd1,  4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2, 4'd11}, // R11 step beats load
    '{4'd15,2'd1, 4'd12, 4'd3,  1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1, 4'd12}  // R12 reserved
  };

  function automatic logic [15:0] init_word(input int i);
    return {8'(i * 3 + 1), 8'(i ^ 8'h3C)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model of one command, applied to m_reg/m_mem
  task automatic model(input vec_t v);
    logic [15:0] p [4];
    logic [15:0] x [4];
    logic [15:0] sv, va, vb, st_s, st_3;
    int s;
    bit ms, m3;
    for (int i = 0; i < 4; i++) begin p[i] = m_reg[i]; x[i] = m_reg[4+i]; end
    sv = m_reg[v.src];
    s = (v.op == 4'd6 || v.op == 4'd7) ? 0 : int'(v.ps);
    st_s = v.n ? x[s] : 16'd1;
    st_3 = v.m ? x[3] : 16'd1;
    ms = 1'b1; m3 = 1'b0;
    case (v.op)
      4'd0: st_s = 16'hFFFF;
      4'd1: st_s = 16'd1;
      4'd2: st_s = x[s];
      4'd3: begin m_reg[v.dst] = sv; ms = 1'b0; end
      4'd4: m_mem[p[s][7:0]] = sv;
      4'd5: m_reg[v.dst] = m_mem[p[s][7:0]];
      4'd6: begin va = m_mem[p[0][7:0]]; m_mem[p[3][7:0]] = sv; m_reg[v.dst] = va; m3 = 1'b1; end
      4'd7: begin va = m_mem[p[3][7:0]]; m_mem[p[0][7:0]] = sv; m_reg[v.dst] = va; m3 = 1'b1; end
      4'd8: begin
        va = m_mem[p[s][7:0]]; vb = m_mem[p[3][7:0]];
        m_reg[v.ha ? 8 : 9] = va; m_reg[v.hb ? 10 : 11] = vb; m3 = 1'b1;
      end
      4'd9: begin
        va = m_mem[p[s][7:0]]; vb = m_mem[p[3][7:0]];
        m_reg[v.sp ? 10 : 8] = va; m_reg[v.sp ? 11 : 9] = vb; m3 = 1'b1;
      end
      default: ms = 1'b0;
    endcase
    if (ms) p[s] = p[s] + st_s;
    if (m3) p[3] = p[3] + st_3;
    if (ms) m_reg[s] = p[s];
    if (m3) m_reg[3] = p[3];
  endtask

  task automatic compare_state(input string req);
    int bad_r, bad_m;
    bad_r = -1; bad_m = -1;
    for (int i = 15; i >= 0; i--) if (reg_view[i*16 +: 16] !== m_reg[i]) bad_r = i;
    if (bad_r < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " reg"}, {16'(bad_r), reg_view[bad_r*16 +: 16]}, {16'(bad_r), m_reg[bad_r]});
    for (int i = 255; i >= 0; i--) if (mem[i] !== m_mem[i]) bad_m = i;
    if (bad_m < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " mem"}, {16'(bad_m), mem[bad_m]}, {16'(bad_m), m_mem[bad_m]});
  endtask

  task automatic run_vec(input vec_t v);
    int lat;
    logic [255:0] snap;
    bit early;
    string rq;
    rq = $sformatf("R%0d", v.req);
    model(v);
    @(negedge clk);
    op_code = v.op; ptr_sel = v.ps; dst_sel = v.dst; src_sel = v.src;
    use_n = v.n; use_m = v.m; half_a = v.ha; half_b = v.hb; split_sel = v.sp;
    op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    snap = reg_view;
    early = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      if (reg_view !== snap) early = 1'b1;
      @(negedge clk);
      lat++;
    end
    chk(lat == int'(v.lat), {"R10 latency ", rq}, lat, v.lat);
    chk(!early && reg_view === snap, {"R9 no early change ", rq}, 0, 0);
    @(negedge clk);
    compare_state(rq);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = init_word(i); m_mem[i] = init_word(i); end
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    mem_rd_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(reg_view == '0, "R1 regs zero", reg_view[31:0], 0);
    chk(ready && !done && !mem_rd_en && !mem_wr_en, "R1 idle outputs",
        {ready, done, mem_rd_en, mem_wr_en}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !done, "R1 ready after release", {ready, done}, 2'b10);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R1 reset mid-command clears everything and returns to idle
    @(negedge clk);
    op_code = 4'd8; ptr_sel = 2'd1; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    chk(reg_view == '0 && ready && !done, "R1 reset during command",
        {reg_view[15:0], 14'd0, ready, done}, 32'h2);
    repeat (2) @(negedge clk);
    chk(!mem_rd_en && !mem_wr_en, "R10 no strobe after reset", {mem_rd_en, mem_wr_en}, 0);

    // R2 increment after reset starts from zero
    run_vec('{4'd1, 2'd0, 4'd0, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 4'd2});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule